// File: doc/BRIEF.md
# Keyed-Write Watchdog and Interval Timer

This block is an 8-bit up-counter driven through a programmable prescaler, with an 8-bit control/status register. The register holds the run enable, the choice between watchdog and interval operation, the kind of reset to request, the prescaler select and two overflow flags. In watchdog mode, software must rewrite the counter before it wraps. If it does not, the block issues a one-cycle reset request and marks it as a power-on or a manual reset. In interval mode, a wrap raises a flag and a one-cycle interrupt pulse instead.

Software stray writes are kept out by a key. A write takes effect only when it is a 16-bit access whose upper byte matches the key for the target. The control register and the counter have different keys. Reads return one byte. The control register is cleared only by the power-on reset input, so its contents, including the flag showing that the watchdog fired, are still there after the system reset that the block requested.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset the control register reads 0x00, the counter reads 0x00, and the rst_req and irq outputs are low.
- R2: A control write (bus_addr=0) takes effect only when bus_wide=1 and bus_wdata[15:8]=0xA5. The new value comes from bus_wdata[7:0]. Any other write leaves the register unchanged.
- R3: A counter write (bus_addr=1) takes effect only when bus_wide=1 and bus_wdata[15:8]=0x5A. It loads bus_wdata[7:0] into the counter and restarts the prescaler.
- R4: When control bit 7 (enable) is 0, the counter holds its value. When it is 1, the counter increments once every 32·2^k clock cycles, where k is control bits 2:0. With the counter at 0xFE and the prescaler cleared, the wrap occurs 64·2^k cycles after the enabling write.
- R5: Control bit 6 (mode: 1 watchdog, 0 interval) keeps its value on a keyed write made while enable is 1. It is writable only while enable is 0.
- R6: In watchdog mode, a wrap from 0xFF to 0x00 sets control bit 4 and pulses rst_req high for one cycle. During that pulse, rst_kind equals control bit 5 (0 power-on, 1 manual).
- R7: In interval mode, a wrap sets control bit 3 and pulses irq high for one cycle. rst_req stays low, and bit 5 has no effect.
- R8: A keyed control write with 0 in bit 4 or bit 3 clears that flag, and a 1 leaves it unchanged. If a wrap sets a flag in the same cycle that a write clears it, the flag ends up set.
- R9: A wrap, and the reset request it causes, does not alter the enable, mode, reset-kind or select fields. Only por_n clears the control register.
- R10: rd_data shows the control register when bus_addr=0 and the counter when bus_addr=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_wide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| bus_addr | input | 1 | 0 selects the control register, 1 selects the counter |
| bus_wdata | input | 16 | Write data: key in the upper byte, value in the lower byte |
| rd_data | output | 8 | Read data for the selected register |
| rst_req | output | 1 | One-cycle reset request on a watchdog wrap |
| rst_kind | output | 1 | Reset kind for the request: 0 power-on, 1 manual |
| irq | output | 1 | One-cycle interrupt on an interval wrap |

## Verification
The hardest case to reach from the ports is a flag-clearing control write that lands on the very cycle of a wrap. The bench gets there by holding the timer disabled, which clears the prescaler, and loading 0xFF into the counter. It then enables the timer with the fastest select and counts exactly 31 more cycles, so that the clearing write is sampled on the wrap edge. The same cycle counting also checks the prescaler ratios and the prescaler restart that a counter write causes.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter logic [7:0] KEY_CTRL  = 8'hA5,
  parameter logic [7:0] KEY_CNT   = 8'h5A,
  parameter int         BASE_LOG2 = 5
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        bus_we,
  input  logic        bus_wide,
  input  logic        bus_addr,
  input  logic [15:0] bus_wdata,
  output logic [7:0]  rd_data,
  output logic        rst_req,
  output logic        rst_kind,
  output logic        irq
);
  localparam int PW = BASE_LOG2 + 7;

  logic [7:0]    ctrl_q, ctrl_d;
  logic [7:0]    cnt_q;
  logic [PW-1:0] pre_q;
  logic          req_q, kind_q, irq_q;

  wire en   = ctrl_q[7];
  wire mode = ctrl_q[6];

  wire ctrl_wr = bus_we && bus_wide && !bus_addr && (bus_wdata[15:8] == KEY_CTRL);
  wire cnt_wr  = bus_we && bus_wide &&  bus_addr && (bus_wdata[15:8] == KEY_CNT);

  wire [PW-1:0] hi_mask = {PW{1'b1}} << (BASE_LOG2 + 32'(ctrl_q[2:0]));
  wire tick = en && ((pre_q | hi_mask) == {PW{1'b1}});
  wire wrap = tick && (cnt_q == 8'hFF) && !cnt_wr;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr) begin
      ctrl_d[7]   = bus_wdata[7];
      ctrl_d[6]   = en ? ctrl_q[6] : bus_wdata[6];
      ctrl_d[5]   = bus_wdata[5];
      ctrl_d[4]   = ctrl_q[4] & bus_wdata[4];
      ctrl_d[3]   = ctrl_q[3] & bus_wdata[3];
      ctrl_d[2:0] = bus_wdata[2:0];
    end
    if (wrap) begin
      if (mode) ctrl_d[4] = 1'b1;
      else      ctrl_d[3] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ctrl_q <= 8'h00;
      cnt_q  <= 8'h00;
      pre_q  <= '0;
      req_q  <= 1'b0;
      kind_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      pre_q  <= (!en || cnt_wr) ? '0 : pre_q + PW'(1);
      if (cnt_wr)    cnt_q <= bus_wdata[7:0];
      else if (tick) cnt_q <= cnt_q + 8'd1;
      req_q  <= wrap && mode;
      irq_q  <= wrap && !mode;
      if (wrap && mode) kind_q <= ctrl_q[5];
    end
  end

  assign rd_data  = bus_addr ? cnt_q : ctrl_q;
  assign rst_req  = req_q;
  assign rst_kind = kind_q;
  assign irq      = irq_q;

  a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> !rst_req);
  a_r6_req_sets_wflag: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> ctrl_q[4]);
  a_r7_irq_sets_iflag: assert property (@(posedge clk) disable iff (!por_n)
    irq |-> (ctrl_q[3] && !rst_req));
  a_r4_hold_when_off: assert property (@(posedge clk) disable iff (!por_n)
    (!en && !cnt_wr) |=> $stable(cnt_q));
  a_r5_mode_locked: assert property (@(posedge clk) disable iff (!por_n)
    en |=> $stable(ctrl_q[6]));
  a_r9_wrap_keeps_fields: assert property (@(posedge clk) disable iff (!por_n)
    (wrap && !ctrl_wr) |=> ($stable(ctrl_q[7:5]) && $stable(ctrl_q[2:0])));
endmodule

// File: tb/wdt_keyed_bench.sv
`timescale 1ns/1ps
module wdt_keyed_bench;
  logic clk = 1'b0, por_n = 1'b0;
  logic bus_we = 1'b0, bus_wide = 1'b0, bus_addr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [7:0] rd_data;
  logic rst_req, rst_kind, irq;
  int n_chk = 0, n_bad = 0;

  wdt_keyed u_wdt_keyed (.clk(clk), .por_n(por_n), .bus_we(bus_we), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rst_req(rst_req), .rst_kind(rst_kind), .irq(irq));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic wide, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_wide = wide; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wide = 1'b0; bus_addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    bus_addr = a; #1; v = rd_data; bus_addr = 1'b0;
  endtask

  task automatic setup(input logic [7:0] ctrl, input logic [7:0] cnt);
    wr(0, 1, 16'hA500); wr(0, 1, 16'hA500);
    wr(1, 1, {8'h5A, cnt}); wr(0, 1, {8'hA5, ctrl});
  endtask

  task automatic wait_ev(input bit want_irq, input int lim, output int n);
    n = 0;
    while (n < lim && !(want_irq ? irq : rst_req)) begin @(negedge clk); n++; end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v); chk("R1 ctrl", v, 8'h00);
    rd(1, v); chk("R1 cnt", v, 8'h00);
    chk("R1 outs", {rst_req, irq}, 0);
  endtask

  task automatic t_keys();
    logic [7:0] v;
    wr(0, 1, 16'h5A80); rd(0, v); chk("R2 wrong key", v, 8'h00);
    wr(0, 0, 16'hA580); rd(0, v); chk("R2 byte access", v, 8'h00);
    wr(0, 1, 16'hA527); rd(0, v); chk("R2 keyed write", v, 8'h27);
    wr(1, 1, 16'hA533); rd(1, v); chk("R3 wrong key", v, 8'h00);
    wr(1, 0, 16'h5A33); rd(1, v); chk("R3 byte access", v, 8'h00);
    wr(1, 1, 16'h5A33); rd(1, v); chk("R3 keyed load", v, 8'h33);
    rd(0, v); chk("R10 ctrl select", v, 8'h27);
  endtask

  task automatic t_rate(input int k);
    int n;
    setup(8'h80 | 8'(k), 8'hFE);
    wait_ev(1, 70000, n);
    chk($sformatf("R4 ratio k=%0d", k), n, 64 << k);
  endtask

  task automatic t_hold();
    logic [7:0] a, b;
    setup(8'h80, 8'h10);
    repeat (100) @(negedge clk);
    rd(1, a); chk("R4 counting", a, 8'h13);
    wr(0, 1, 16'hA500);
    rd(1, a); repeat (200) @(negedge clk); rd(1, b);
    chk("R4 hold", b, a);
  endtask

  task automatic t_restart();
    int n;
    setup(8'h80, 8'h00);
    repeat (20) @(negedge clk);
    wr(1, 1, 16'h5AFE);
    wait_ev(1, 1000, n);
    chk("R3 prescaler restart", n, 64);
  endtask

  task automatic t_mode_lock();
    logic [7:0] v;
    setup(8'h80, 8'h00);
    wr(0, 1, 16'hA5C0); rd(0, v); chk("R5 locked on", v, 8'h80);
    wr(0, 1, 16'hA540); rd(0, v); chk("R5 locked at stop", v, 8'h00);
    wr(0, 1, 16'hA540); rd(0, v); chk("R5 free when off", v, 8'h40);
  endtask

  task automatic t_watchdog(input bit manual);
    int n; logic [7:0] v;
    setup(manual ? 8'hE0 : 8'hC0, 8'hFF);
    wait_ev(0, 1000, n);
    chk("R6 wrap time", n, 32);
    chk("R6 kind", rst_kind, manual);
    chk("R7 no irq in watchdog", irq, 0);
    @(negedge clk); chk("R6 one cycle", rst_req, 0);
    rd(0, v); chk("R9 ctrl kept", v, manual ? 8'hF0 : 8'hD0);
    rd(1, v); chk("R6 wrapped", v, 8'h00);
  endtask

  task automatic t_interval();
    int n; logic [7:0] v; bit saw = 0;
    setup(8'hA0, 8'hFF);
    n = 0;
    while (n < 40 && !irq) begin @(negedge clk); n++; saw |= rst_req; end
    chk("R7 irq time", n, 32);
    chk("R7 no rst_req", saw | rst_req, 0);
    @(negedge clk); chk("R7 one cycle", irq, 0);
    rd(0, v); chk("R7 flag", v, 8'hA8);
  endtask

  task automatic t_flags();
    logic [7:0] v;
    t_watchdog(0);
    wr(0, 1, 16'hA550); rd(0, v); chk("R8 write 1 keeps", v, 8'h50);
    wr(0, 1, 16'hA540); rd(0, v); chk("R8 write 0 clears", v, 8'h40);
    setup(8'h00, 8'hFF);
    wr(0, 1, 16'hA580);
    repeat (31) @(negedge clk);
    bus_we = 1'b1; bus_wide = 1'b1; bus_addr = 1'b0; bus_wdata = 16'hA580;
    @(negedge clk);
    bus_we = 1'b0; bus_wide = 1'b0;
    chk("R8 irq at collision", irq, 1);
    rd(0, v); chk("R8 set wins", v, 8'h88);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    por_n = 1'b1;
    @(negedge clk);
    t_keys();
    t_rate(0); t_rate(1); t_rate(3); t_rate(7);
    t_hold();
    t_restart();
    t_mode_lock();
    t_watchdog(0);
    t_watchdog(1);
    t_interval();
    t_flags();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule